// File: doc/BRIEF.md
# Vertical Interval Time Code Line Inserter

This block turns a host-supplied time code payload into a serial vertical interval time code word and places it on up to two chosen video lines per field. The host writes a 64-bit payload (time and user bits) and two line numbers. A video timing generator, genlocked or free running, supplies a horizontal sync strobe, the current line number and a field start strobe. The block frames the payload into nine ten-bit groups, adds the sync pairs and a checksum byte, and drives a one-bit serial output together with a gate that tells an external overlay mixer when the code is present.

Host writes land in a pending copy and become active only at the next field start. The active copy is latched into the serializer when a word begins, so a later commit never disturbs a word already on its way. Pixel timing is one clock per pixel: each code bit lasts a fixed number of clocks, and the word starts a fixed number of clocks after the sync strobe of the selected line.

Top module: `vitc_line_inserter`

## Requirements
- R1: After reset `code_out` and `code_gate` are low, and the active line numbers are zero, so no word is sent until a host write has been committed.
- R2: A host write (`host_we`) goes into a pending copy only. `field_start` copies the pending values to the active copy. A write in the same cycle as `field_start` becomes active at that strobe.
- R3: A word starts when `hs_strobe` is sampled while `cur_line` equals an active line number within 10 to 40 inclusive. Numbers outside that range never start a word. Two equal line numbers give one word per line.
- R4: `code_gate` rises START_OFS clocks after the edge that samples the starting `hs_strobe`. It stays high for exactly 90 × BIT_CLKS clocks, and each bit is held for BIT_CLKS clocks.
- R5: The word is nine groups of ten bits. Each group opens with a 1 and then a 0, followed by eight data bits.
- R6: The data bits of groups 0 to 7 are `host_payload[8g+i]`, i = 0..7 in that order, sent as written with no change.
- R7: The data bits of group 8 are a checksum c, sent c[7] first down to c[0]. Bit c[j] is the XOR of the word bits k (k = 0..81, in send order) for which (81 − k) mod 8 = j. This is polynomial x^8 + 1 with an all-zero start.
- R8: `code_out` is low whenever `code_gate` is low.
- R9: An `hs_strobe` that arrives while a word is waiting to start or is being sent is ignored. A commit during a word does not change that word. The next word uses the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_we | input | 1 | Host write strobe for payload and line numbers |
| host_payload | input | 64 | Time and user-bit payload, bit 0 sent first |
| host_line_a | input | 6 | First insertion line number |
| host_line_b | input | 6 | Second insertion line number |
| field_start | input | 1 | Start-of-vertical-interval strobe from the timing generator |
| hs_strobe | input | 1 | Horizontal sync strobe, one clock per line |
| cur_line | input | 6 | Line number valid with `hs_strobe` |
| code_out | output | 1 | Serial time code data |
| code_gate | output | 1 | High while code bits are driven |

## Verification
Two events can land in the same clock: a host write and the field start strobe that commits it. A commit can also arrive while a word is in flight, and so can a second matching sync strobe. The bench provokes each case on purpose. It writes in the exact cycle of `field_start`, issues a commit and a matching `hs_strobe` partway through a word, and then judges every clock against a behavioural model. That model captures the payload at the start of a word and updates its active copy only on the strobe. It also checks the number of words seen in each scenario, which shows whether the new values appear in the right word and whether the stray strobe was ignored.

// File: rtl/vitc_pkg.sv
package vitc_pkg;
   localparam int GRP_CNT  = 9;
   localparam int GRP_LEN  = 10;
   localparam int SYNC_LEN = 2;
   localparam int DATA_LEN = 8;
   localparam int WORD_LEN = GRP_CNT * GRP_LEN;
   localparam int PAY_LEN  = (GRP_CNT - 1) * DATA_LEN;
   localparam int CRC_LEN  = DATA_LEN;
   localparam int CRC_SPAN = WORD_LEN - CRC_LEN;
   localparam int LINE_W   = 6;

   typedef enum logic [1:0] {
      SER_IDLE = 2'd0,
      SER_WAIT = 2'd1,
      SER_SEND = 2'd2
   } ser_state_e;
endpackage

// File: rtl/vitc_shadow.sv
module vitc_shadow #(
   parameter int DATA_W = 76
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit,
   output logic [DATA_W-1:0] act_data
);
   logic [DATA_W-1:0] pend_q;
   logic [DATA_W-1:0] act_q;

   initial begin
      assert (DATA_W >= 1) else $error("vitc_shadow: DATA_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (wr_en)
            pend_q <= wr_data;
         if (commit)
            act_q <= wr_en ? wr_data : pend_q;
      end
   end

   assign act_data = act_q;

   // R2
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act_q));
endmodule

// File: rtl/vitc_line_match.sv
module vitc_line_match #(
   parameter int NUM_SLOTS = 2,
   parameter int LINE_W    = 6,
   parameter int LINE_MIN  = 10,
   parameter int LINE_MAX  = 40
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        hs_strobe,
   input  logic [LINE_W-1:0]           cur_line,
   input  logic [NUM_SLOTS*LINE_W-1:0] act_lines,
   output logic                        hit
);
   logic [NUM_SLOTS-1:0] slot_hit;

   initial begin
      assert (NUM_SLOTS >= 1) else $error("vitc_line_match: need at least one slot");
      assert (LINE_MIN <= LINE_MAX) else $error("vitc_line_match: empty line window");
      assert (LINE_MAX < (1 << LINE_W)) else $error("vitc_line_match: LINE_W too narrow");
   end

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [LINE_W-1:0] ln;
      logic              in_win;
      assign ln       = act_lines[s*LINE_W +: LINE_W];
      assign in_win   = (int'(ln) >= LINE_MIN) && (int'(ln) <= LINE_MAX);
      assign slot_hit[s] = in_win && (ln == cur_line);
   end

   assign hit = hs_strobe && (|slot_hit);

   // R3
   line_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (int'(cur_line) >= LINE_MIN && int'(cur_line) <= LINE_MAX));
endmodule

// File: rtl/vitc_crc.sv
module vitc_crc #(
   parameter int CRC_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic upd,
   input  logic din,
   input  logic shift_out,
   output logic msb
);
   logic [CRC_W-1:0] crc_q;

   initial begin
      assert (CRC_W >= 2) else $error("vitc_crc: CRC_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= '0;
      else if (clr)
         crc_q <= '0;
      else if (upd)
         crc_q <= {crc_q[CRC_W-2:0], crc_q[CRC_W-1] ^ din};
      else if (shift_out)
         crc_q <= {crc_q[CRC_W-2:0], 1'b0};
   end

   assign msb = crc_q[CRC_W-1];
endmodule

// File: rtl/vitc_serializer.sv
module vitc_serializer
   import vitc_pkg::*;
#(
   parameter int START_OFS   = 20,
   parameter int BIT_CLKS    = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hit,
   input  logic [PAY_LEN-1:0] act_payload,
   output logic               ser_data,
   output logic               ser_gate
);
   localparam int OFS_W  = $clog2(START_OFS + 1);
   localparam int PIX_W  = $clog2(BIT_CLKS + 1);
   localparam int GRP_W  = $clog2(GRP_CNT + 1);
   localparam int POS_W  = $clog2(GRP_LEN + 1);
   localparam int GATE_CLKS = WORD_LEN * BIT_CLKS;
   localparam int GL_W   = $clog2(GATE_CLKS + 1) + 1;

   initial begin
      assert (START_OFS >= 1) else $error("vitc_serializer: START_OFS must be >= 1");
      assert (BIT_CLKS >= 1) else $error("vitc_serializer: BIT_CLKS must be >= 1");
   end

   ser_state_e         state_q;
   logic [OFS_W-1:0]   ofs_q;
   logic [PIX_W-1:0]   pix_q;
   logic [GRP_W-1:0]   grp_q;
   logic [POS_W-1:0]   pos_q;
   logic [PAY_LEN-1:0] pay_q;
   logic               data_q;
   logic               gate_q;

   logic               take, ofs_done, pix_done, last_bit, advance;
   logic [POS_W-1:0]   nxt_pos;
   logic [GRP_W-1:0]   nxt_grp;
   logic               is_sync, is_crc, nxt_bit, crc_msb;

   always_comb begin
      take     = (state_q == SER_IDLE) && hit;
      ofs_done = (state_q == SER_WAIT) && (ofs_q == '0);
      pix_done = (state_q == SER_SEND) && (pix_q == '0);
      last_bit = (grp_q == GRP_W'(GRP_CNT - 1)) && (pos_q == POS_W'(GRP_LEN - 1));
      advance  = ofs_done || (pix_done && !last_bit);
      if (ofs_done) begin
         nxt_pos = '0;
         nxt_grp = '0;
      end else if (pos_q == POS_W'(GRP_LEN - 1)) begin
         nxt_pos = '0;
         nxt_grp = grp_q + 1'b1;
      end else begin
         nxt_pos = pos_q + 1'b1;
         nxt_grp = grp_q;
      end
      is_sync = (nxt_pos < POS_W'(SYNC_LEN));
      is_crc  = !is_sync && (nxt_grp == GRP_W'(GRP_CNT - 1));
      if (is_sync)
         nxt_bit = (nxt_pos == '0);
      else if (is_crc)
         nxt_bit = crc_msb;
      else
         nxt_bit = pay_q[0];
   end

   vitc_crc #(.CRC_W(CRC_LEN)) u_crc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (take),
      .upd       (advance && !is_crc),
      .din       (nxt_bit),
      .shift_out (advance && is_crc),
      .msb       (crc_msb)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SER_IDLE;
         ofs_q   <= '0;
         pix_q   <= '0;
         grp_q   <= '0;
         pos_q   <= '0;
         pay_q   <= '0;
         data_q  <= 1'b0;
         gate_q  <= 1'b0;
      end else begin
         case (state_q)
            SER_IDLE: begin
               if (hit) begin
                  state_q <= SER_WAIT;
                  ofs_q   <= OFS_W'(START_OFS - 1);
                  pay_q   <= act_payload;
               end
            end
            SER_WAIT: begin
               if (ofs_q == '0) begin
                  state_q <= SER_SEND;
                  gate_q  <= 1'b1;
                  pix_q   <= PIX_W'(BIT_CLKS - 1);
               end else begin
                  ofs_q <= ofs_q - 1'b1;
               end
            end
            SER_SEND: begin
               if (pix_q == '0) begin
                  if (last_bit) begin
                     state_q <= SER_IDLE;
                     gate_q  <= 1'b0;
                     data_q  <= 1'b0;
                  end else begin
                     pix_q <= PIX_W'(BIT_CLKS - 1);
                  end
               end else begin
                  pix_q <= pix_q - 1'b1;
               end
            end
            default: state_q <= SER_IDLE;
         endcase
         if (advance) begin
            data_q <= nxt_bit;
            pos_q  <= nxt_pos;
            grp_q  <= nxt_grp;
            if (!is_sync && !is_crc)
               pay_q <= pay_q >> 1;
         end
      end
   end

   assign ser_data = data_q;
   assign ser_gate = gate_q;

   // gate length observer for the width check
   logic [GL_W-1:0] gl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gl_q <= '0;
      else
         gl_q <= gate_q ? gl_q + 1'b1 : '0;
   end

   // R4
   gate_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_gate) |-> (gl_q == GL_W'(GATE_CLKS)));

   // R5
   first_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_gate) |-> ser_data);

   // R8
   quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_gate |-> !ser_data);

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SER_SEND && hit) |=> $stable(pay_q) || advance || $past(advance));
endmodule

// File: rtl/vitc_line_inserter.sv
module vitc_line_inserter
   import vitc_pkg::*;
#(
   parameter int START_OFS = 20,
   parameter int BIT_CLKS  = 4,
   parameter int LINE_MIN  = 10,
   parameter int LINE_MAX  = 40
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_we,
   input  logic [PAY_LEN-1:0]   host_payload,
   input  logic [LINE_W-1:0]    host_line_a,
   input  logic [LINE_W-1:0]    host_line_b,
   input  logic                 field_start,
   input  logic                 hs_strobe,
   input  logic [LINE_W-1:0]    cur_line,
   output logic                 code_out,
   output logic                 code_gate
);
   localparam int NUM_SLOTS = 2;
   localparam int LINES_W   = NUM_SLOTS * LINE_W;
   localparam int SHADOW_W  = PAY_LEN + LINES_W;

   logic [SHADOW_W-1:0] act_all;
   logic [LINES_W-1:0]  act_lines;
   logic [PAY_LEN-1:0]  act_payload;
   logic                hit;

   vitc_shadow #(.DATA_W(SHADOW_W)) u_shadow (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_we),
      .wr_data  ({host_payload, host_line_b, host_line_a}),
      .commit   (field_start),
      .act_data (act_all)
   );

   assign act_payload = act_all[SHADOW_W-1 -: PAY_LEN];
   assign act_lines   = act_all[LINES_W-1:0];

   vitc_line_match #(
      .NUM_SLOTS (NUM_SLOTS),
      .LINE_W    (LINE_W),
      .LINE_MIN  (LINE_MIN),
      .LINE_MAX  (LINE_MAX)
   ) u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .hs_strobe (hs_strobe),
      .cur_line  (cur_line),
      .act_lines (act_lines),
      .hit       (hit)
   );

   vitc_serializer #(
      .START_OFS (START_OFS),
      .BIT_CLKS  (BIT_CLKS)
   ) u_ser (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit         (hit),
      .act_payload (act_payload),
      .ser_data    (code_out),
      .ser_gate    (code_gate)
   );
endmodule

// File: tb/sim_vitc_line_inserter.sv
`timescale 1ns/1ps
module sim_vitc_line_inserter;
   localparam int S      = 20;
   localparam int P      = 4;
   localparam int LPER   = 420;
   localparam int ENDK   = S + 90 * P;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [63:0] host_payload = '0;
   logic [5:0]  host_line_a = '0;
   logic [5:0]  host_line_b = '0;
   logic        field_start = 1'b0;
   logic        hs_strobe = 1'b0;
   logic [5:0]  cur_line = '0;
   logic        code_out, code_gate;

   always #2.5 clk = ~clk;

   vitc_line_inserter #(.START_OFS(S), .BIT_CLKS(P)) u0 (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_payload(host_payload),
      .host_line_a(host_line_a), .host_line_b(host_line_b), .field_start(field_start),
      .hs_strobe(hs_strobe), .cur_line(cur_line), .code_out(code_out), .code_gate(code_gate));

   int checks = 0, errors = 0, rises = 0;
   bit done = 0;
   bit prev_gate = 0;
   string scen = "R1";

   // reference model state
   logic [63:0] m_pay_act, m_pay_pend;
   logic [5:0]  m_la, m_lb, m_pa, m_pb;
   logic [89:0] m_bits;
   bit          m_busy;
   int          m_k, exp_idx;
   logic        exp_gate, exp_data;

   function automatic bit ok_line(input logic [5:0] l);
      return (l >= 6'd10) && (l <= 6'd40);
   endfunction

   function automatic logic [89:0] build_word(input logic [63:0] pay);
      logic [89:0] w;
      logic [7:0]  c;
      w = '0;
      for (int g = 0; g < 9; g++) begin
         w[10*g]   = 1'b1;
         w[10*g+1] = 1'b0;
         if (g < 8)
            for (int i = 0; i < 8; i++) w[10*g+2+i] = pay[8*g+i];
      end
      c = '0;
      for (int k = 0; k < 82; k++) c[(81-k) % 8] = c[(81-k) % 8] ^ w[k];
      for (int m = 0; m < 8; m++) w[82+m] = c[7-m];
      return w;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pay_act = '0; m_pay_pend = '0; m_la = '0; m_lb = '0; m_pa = '0; m_pb = '0;
         m_busy = 0; m_k = 0; exp_gate = 0; exp_data = 0; exp_idx = 0;
      end else begin
         if (m_busy) begin
            m_k++;
            exp_gate = (m_k >= S) && (m_k < ENDK);
            exp_idx  = exp_gate ? (m_k - S) / P : 0;
            exp_data = exp_gate ? m_bits[exp_idx] : 1'b0;
            if (m_k == ENDK) m_busy = 0;
         end else begin
            exp_gate = 0; exp_data = 0;
            if (hs_strobe && ((cur_line == m_la && ok_line(m_la)) ||
                              (cur_line == m_lb && ok_line(m_lb)))) begin
               m_busy = 1; m_k = 0; m_bits = build_word(m_pay_act);
            end
         end
         if (field_start) begin
            m_pay_act = host_we ? host_payload : m_pay_pend;
            m_la      = host_we ? host_line_a  : m_pa;
            m_lb      = host_we ? host_line_b  : m_pb;
         end
         if (host_we) begin
            m_pay_pend = host_payload; m_pa = host_line_a; m_pb = host_line_b;
         end
      end
   end

   // per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (code_gate !== exp_gate) begin
            errors++;
            $display("FAIL R4 [%s] gate actual=%b expected=%b t=%0t", scen, code_gate, exp_gate, $time);
         end else if (code_out !== exp_data) begin
            errors++;
            if (!exp_gate)
               $display("FAIL R8 [%s] data actual=%b expected=%b t=%0t", scen, code_out, exp_data, $time);
            else if ((exp_idx % 10) < 2)
               $display("FAIL R5 [%s] bit %0d actual=%b expected=%b", scen, exp_idx, code_out, exp_data);
            else if (exp_idx >= 82)
               $display("FAIL R7 [%s] bit %0d actual=%b expected=%b", scen, exp_idx, code_out, exp_data);
            else
               $display("FAIL R6 [%s] bit %0d actual=%b expected=%b", scen, exp_idx, code_out, exp_data);
         end
         if (code_gate && !prev_gate) rises++;
         prev_gate = code_gate;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic host_write(input logic [63:0] pay, input logic [5:0] a, input logic [5:0] b,
                             input bit with_start);
      @(negedge clk);
      host_we = 1; host_payload = pay; host_line_a = a; host_line_b = b;
      field_start = with_start;
      @(negedge clk);
      host_we = 0; field_start = 0;
   endtask

   task automatic hsync_pulse(input logic [5:0] l);
      @(negedge clk);
      hs_strobe = 1; cur_line = l;
      @(negedge clk);
      hs_strobe = 0;
   endtask

   task automatic run_lines(input bit with_start);
      if (with_start) begin
         @(negedge clk); field_start = 1;
         @(negedge clk); field_start = 0;
         tick(4);
      end
      for (int l = 8; l <= 42; l++) begin
         hsync_pulse(6'(l));
         tick(LPER - 2);
      end
   endtask

   task automatic expect_words(input int n, input string tag);
      checks++;
      if (rises != n) begin
         errors++;
         $display("FAIL %s word count actual=%0d expected=%0d", tag, rises, n);
      end
      rises = 0;
   endtask

   initial begin
      tick(5);
      // R1: reset state
      checks++;
      if (code_gate !== 1'b0 || code_out !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset outputs actual=%b%b expected=00", code_gate, code_out);
      end
      rst_n = 1;
      tick(3);
      scen = "R1";
      run_lines(1);
      expect_words(0, "R1");

      // R2: pending write has no effect before field start
      scen = "R2";
      host_write(64'h0123_4567_89AB_CDEF, 6'd10, 6'd40, 0);
      run_lines(0);
      expect_words(0, "R2");
      scen = "R6";
      run_lines(1);
      expect_words(2, "R6");

      // R2 + R3: write in same cycle as field start, equal line numbers
      scen = "R3";
      host_write(64'hFFFF_FFFF_FFFF_FFFF, 6'd12, 6'd12, 1);
      run_lines(0);
      expect_words(1, "R3");

      // R3: out-of-window line numbers
      scen = "R3";
      host_write(64'hA5A5_5A5A_0F0F_F0F0, 6'd9, 6'd41, 0);
      run_lines(1);
      expect_words(0, "R3");

      // R9: matching strobe during a word, commit during a word
      scen = "R9";
      host_write(64'h8000_0000_0000_0001, 6'd11, 6'd20, 1);
      tick(5);
      hsync_pulse(6'd11);
      tick(100);
      hsync_pulse(6'd20);
      tick(50);
      host_write(64'h1357_9BDF_2468_ACE0, 6'd20, 6'd33, 1);
      tick(LPER);
      hsync_pulse(6'd20);
      tick(LPER);
      expect_words(2, "R9");

      // R7 / R6: another payload on the window edges
      scen = "R7";
      host_write(64'h0000_0000_0000_0000, 6'd40, 6'd10, 0);
      run_lines(1);
      expect_words(2, "R7");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(190000 * 5);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule